// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the transmit and receive engine of a byte-wide SPI master. Software writes a byte to the data port, and that write alone starts a transfer. The engine then generates the serial clock, shifts the byte out most significant bit first, and shifts the incoming line into a receive register. When the last bit completes, the received byte is copied into a read buffer, a buffer-full status goes high, and an interrupt flag follows one clock later.

Three configuration inputs set the serial waveform. One picks the idle level of the clock. One picks whether the clock is active in the first or the second half of each bit. One picks whether the input line is captured at mid-bit or at the end of the bit. A two-bit select chooses the bit rate: system clock divided by 4, 16 or 64, or one clock half per pulse of an external timer tick (the timer rate divided by two). When the serial output enable is low, the engine still clocks and captures the input line. Each completed byte is reported exactly as in a normal transfer, so the engine can act as a line monitor.

Top module: `spim_core`

## Requirements
- R1: Bits leave on `sdo` most significant first. The first bit captured from `sdi` ends up in bit 7 of the received byte.
- R2: Each bit lasts two clock halves. With `rateSel` 0, 1 or 2, one half lasts 2, 8 or 32 clocks, so the buffer load happens 32, 128 or 512 clocks after the starting write edge. With `rateSel` 3, each `timerTick` pulse ends one half.
- R3: A write (`bufWrEn`) while idle starts a transfer at once. In the first cycle after the write edge, `sdo` already shows bit 7 of the written byte.
- R4: While no transfer runs, `sck` equals `cpol` (low for 0, high for 1).
- R5: With `earlyData`=1, `sck` is at its idle level in the first half of each bit and active in the second. With `earlyData`=0, it is active in the first half and idle in the second. `sdo` changes only at the start of a bit.
- R6: With `sampleLate`=0, `sdi` is captured at the end of the first half of each bit. With `sampleLate`=1, it is captured at the end of the second half.
- R7: With `sdoEnable`=0, `sdoOe` is low for the whole transfer. The received byte, `bufFull` and `xferIrq` still behave as in a normal transfer.
- R8: The received byte appears on `bufRdData` and `bufFull` rises in the cycle after the final half ends. `xferIrq` rises one cycle after that.
- R9: A `bufRdEn` pulse clears `bufFull` and leaves `bufRdData` unchanged.
- R10: A write during a transfer does not change the byte being sent. It sets `wrCollide`, which stays set until `wrCollideClr`.
- R11: `xferIrq` stays high until an `irqClr` pulse clears it.
- R12: After reset, `xferIrq`, `bufFull` and `wrCollide` are 0, `bufRdData` is 0 and `sck` is at the `cpol` level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bufWrEn | input | 1 | Write strobe for the transmit byte |
| bufWrData | input | 8 | Byte to transmit |
| bufRdEn | input | 1 | Read strobe, clears buffer-full |
| bufRdData | output | 8 | Last received byte |
| bufFull | output | 1 | A received byte is waiting to be read |
| cpol | input | 1 | Clock idle level |
| earlyData | input | 1 | 1: data ahead of first clock edge; 0: data changes on the first edge |
| sampleLate | input | 1 | 0: capture at mid-bit; 1: capture at end of bit |
| rateSel | input | 2 | Bit rate select (0:/4, 1:/16, 2:/64, 3:timer/2) |
| timerTick | input | 1 | External timer pulse, one clock wide |
| sdoEnable | input | 1 | Serial output enable setting |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable for `sdo` |
| sdi | input | 1 | Serial data in |
| xferIrq | output | 1 | Transfer-complete flag |
| irqClr | input | 1 | Clears `xferIrq` |
| wrCollide | output | 1 | A write arrived during a transfer |
| wrCollideClr | input | 1 | Clears `wrCollide` |

## Verification
The bench sweeps every combination of rate, clock polarity, clock phase and sample point. It drives `sdi` with different values in the two halves of each bit, so a capture at the wrong point produces the wrong byte rather than a lucky match. It checks `sck` and `sdo` in every cycle against a half-by-half model. A phase mix-up shows as the clock active in the wrong half, and an off-by-one divider shows as a wrong completion cycle. It also checks that the interrupt lags the buffer load by exactly one cycle, that a mid-transfer write leaves the outgoing bits untouched while raising the collision flag, and that a receive-only transfer still delivers its byte with the output enable held low.

// File: rtl/spim_pkg.sv
package spim_pkg;

  // Rate select codes
  localparam logic [1:0] RATE_DIV_A = 2'd0;
  localparam logic [1:0] RATE_DIV_B = 2'd1;
  localparam logic [1:0] RATE_DIV_C = 2'd2;
  localparam logic [1:0] RATE_TIMER = 2'd3;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture transmit byte, clear receive register
    logic shiftTx;  // advance to next outgoing bit
    logic sample;   // capture sdi into receive register
    logic finish;   // copy received byte into buffer
  } spimStrobe_t;

endpackage

// File: rtl/spim_ctrl.sv
module spim_ctrl
  import spim_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_A  = 4,
  parameter int DIV_B  = 16,
  parameter int DIV_C  = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        bufWrEn,
  input  logic [1:0]  rateSel,
  input  logic        timerTick,
  input  logic        earlyData,
  input  logic        sampleLate,
  input  logic        irqClr,
  input  logic        wrCollideClr,
  output spimStrobe_t strobe,
  output logic        running,
  output logic        sckActive,
  output logic        xferIrq,
  output logic        wrCollide
);

  localparam int HALF_A = DIV_A / 2;
  localparam int HALF_B = DIV_B / 2;
  localparam int HALF_C = DIV_C / 2;
  localparam int CNT_W  = $clog2(HALF_C + 1);
  localparam int BIT_W  = (DATA_W > 2) ? $clog2(DATA_W) : 1;

  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] halfLast;
  logic [BIT_W-1:0] bitCnt;
  logic             phaseHi;
  logic             irqPend;
  logic             useTimer;
  logic             halfTick;
  logic             lastBit;
  logic             startXfer;

  // Half-period length per rate
  always_comb begin
    unique case (rateSel)
      RATE_DIV_A: halfLast = CNT_W'(HALF_A - 1);
      RATE_DIV_B: halfLast = CNT_W'(HALF_B - 1);
      RATE_DIV_C: halfLast = CNT_W'(HALF_C - 1);
      default:    halfLast = '0;
    endcase
  end

  assign useTimer  = (rateSel == RATE_TIMER);
  assign halfTick  = running && (useTimer ? timerTick : (divCnt == halfLast));
  assign lastBit   = (bitCnt == BIT_W'(DATA_W - 1));
  assign startXfer = !running && bufWrEn;

  always_comb begin
    strobe.load    = startXfer;
    strobe.sample  = halfTick && (phaseHi == sampleLate);
    strobe.shiftTx = halfTick && phaseHi && !lastBit;
    strobe.finish  = halfTick && phaseHi && lastBit;
  end

  // Clock active half follows phase setting
  assign sckActive = running && (earlyData ? phaseHi : !phaseHi);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running   <= 1'b0;
      phaseHi   <= 1'b0;
      bitCnt    <= '0;
      divCnt    <= '0;
      irqPend   <= 1'b0;
      xferIrq   <= 1'b0;
      wrCollide <= 1'b0;
    end else begin
      if (startXfer) begin
        running <= 1'b1;
        phaseHi <= 1'b0;
        bitCnt  <= '0;
      end else if (halfTick) begin
        phaseHi <= !phaseHi;
        if (phaseHi) begin
          if (lastBit) running <= 1'b0;
          else         bitCnt  <= bitCnt + BIT_W'(1);
        end
      end

      if (!running || useTimer || divCnt == halfLast) divCnt <= '0;
      else                                              divCnt <= divCnt + CNT_W'(1);

      irqPend <= strobe.finish;
      if (irqPend)     xferIrq <= 1'b1;
      else if (irqClr) xferIrq <= 1'b0;

      if (running && bufWrEn) wrCollide <= 1'b1;
      else if (wrCollideClr)  wrCollide <= 1'b0;
    end
  end

endmodule

// File: rtl/spim_dp.sv
module spim_dp
  import spim_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  spimStrobe_t       strobe,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic              sdi,
  output logic              sdo,
  output logic [DATA_W-1:0] rdData,
  output logic              full
);

  logic [DATA_W-1:0] txSr;
  logic [DATA_W-1:0] rxSr;
  logic [DATA_W-1:0] rxNext;

  assign rxNext = {rxSr[DATA_W-2:0], sdi};
  assign sdo    = txSr[DATA_W-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSr   <= '0;
      rxSr   <= '0;
      rdData <= '0;
      full   <= 1'b0;
    end else begin
      if (strobe.load)         txSr <= wrData;
      else if (strobe.shiftTx) txSr <= {txSr[DATA_W-2:0], 1'b0};

      if (strobe.load)        rxSr <= '0;
      else if (strobe.sample) rxSr <= rxNext;

      // The final capture may land on the same edge as the copy
      if (strobe.finish) rdData <= strobe.sample ? rxNext : rxSr;

      if (strobe.finish) full <= 1'b1;
      else if (rdEn)     full <= 1'b0;
    end
  end

endmodule

// File: rtl/spim_core.sv
module spim_core
  import spim_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_A  = 4,
  parameter int DIV_B  = 16,
  parameter int DIV_C  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bufWrEn,
  input  logic [DATA_W-1:0] bufWrData,
  input  logic              bufRdEn,
  output logic [DATA_W-1:0] bufRdData,
  output logic              bufFull,
  input  logic              cpol,
  input  logic              earlyData,
  input  logic              sampleLate,
  input  logic [1:0]        rateSel,
  input  logic              timerTick,
  input  logic              sdoEnable,
  output logic              sck,
  output logic              sdo,
  output logic              sdoOe,
  input  logic              sdi,
  output logic              xferIrq,
  input  logic              irqClr,
  output logic              wrCollide,
  input  logic              wrCollideClr
);

  spimStrobe_t strobe;
  logic        running;
  logic        sckActive;

  spim_ctrl #(
    .DATA_W(DATA_W), .DIV_A(DIV_A), .DIV_B(DIV_B), .DIV_C(DIV_C)
  ) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .bufWrEn      (bufWrEn),
    .rateSel      (rateSel),
    .timerTick    (timerTick),
    .earlyData    (earlyData),
    .sampleLate   (sampleLate),
    .irqClr       (irqClr),
    .wrCollideClr (wrCollideClr),
    .strobe       (strobe),
    .running      (running),
    .sckActive    (sckActive),
    .xferIrq      (xferIrq),
    .wrCollide    (wrCollide)
  );

  spim_dp #(.DATA_W(DATA_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (bufWrData),
    .rdEn   (bufRdEn),
    .sdi    (sdi),
    .sdo    (sdo),
    .rdData (bufRdData),
    .full   (bufFull)
  );

  assign sck   = cpol ^ sckActive;
  assign sdoOe = sdoEnable;

endmodule

// File: rtl/spim_chk.sv
module spim_chk (
  input logic clk,
  input logic rstN,
  input logic running,
  input logic bufWrEn,
  input logic bufRdEn,
  input logic bufFull,
  input logic xferIrq,
  input logic irqClr,
  input logic wrCollide,
  input logic sck,
  input logic cpol
);

  // R4
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> sck == cpol);

  // R3
  write_starts_chk: assert property (@(posedge clk) disable iff (!rstN)
    !running && bufWrEn |=> running);

  // R8
  irq_follows_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufFull) |=> xferIrq);

  // R9
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    bufRdEn && !running |=> !bufFull);

  // R10
  collide_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    running && bufWrEn |=> wrCollide);

  // R11
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferIrq && !irqClr |=> xferIrq);

endmodule

bind spim_core spim_chk u_spimChk (
  .clk       (clk),
  .rstN      (rstN),
  .running   (running),
  .bufWrEn   (bufWrEn),
  .bufRdEn   (bufRdEn),
  .bufFull   (bufFull),
  .xferIrq   (xferIrq),
  .irqClr    (irqClr),
  .wrCollide (wrCollide),
  .sck       (sck),
  .cpol      (cpol)
);

// File: tb/test_spim_core.sv
`timescale 1ns/100ps
module test_spim_core;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       bufWrEn = 1'b0;
  logic [7:0] bufWrData = '0;
  logic       bufRdEn = 1'b0;
  logic [7:0] bufRdData;
  logic       bufFull;
  logic       cpol = 1'b0;
  logic       earlyData = 1'b0;
  logic       sampleLate = 1'b0;
  logic [1:0] rateSel = '0;
  logic       timerTick = 1'b0;
  logic       sdoEnable = 1'b1;
  logic       sck;
  logic       sdo;
  logic       sdoOe;
  logic       sdi = 1'b0;
  logic       xferIrq;
  logic       irqClr = 1'b0;
  logic       wrCollide;
  logic       wrCollideClr = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  spim_core i_spim_core (
    .clk(clk), .rstN(rstN), .bufWrEn(bufWrEn), .bufWrData(bufWrData),
    .bufRdEn(bufRdEn), .bufRdData(bufRdData), .bufFull(bufFull),
    .cpol(cpol), .earlyData(earlyData), .sampleLate(sampleLate),
    .rateSel(rateSel), .timerTick(timerTick), .sdoEnable(sdoEnable),
    .sck(sck), .sdo(sdo), .sdoOe(sdoOe), .sdi(sdi), .xferIrq(xferIrq),
    .irqClr(irqClr), .wrCollide(wrCollide), .wrCollideClr(wrCollideClr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic runXfer(input int rate, input bit pol, input bit early,
                         input bit late, input bit oe, input logic [7:0] tx,
                         input logic [7:0] mid, input logic [7:0] fin,
                         input bit collide);
    int n, h, halfLen, bitIx, badSck, badSdo, badOe, expN;
    bit hi, tick;
    logic [7:0] expRx;
    n = 0; h = 0; badSck = 0; badSdo = 0; badOe = 0;
    halfLen = (rate == 0) ? 2 : (rate == 1) ? 8 : 32;
    expN = (rate == 0) ? 32 : (rate == 1) ? 128 : (rate == 2) ? 512 : 47;
    expRx = late ? fin : mid;
    rateSel = 2'(rate); cpol = pol; earlyData = early; sampleLate = late;
    sdoEnable = oe; bufWrData = tx; bufWrEn = 1'b1; sdi = mid[7];
    step();
    bufWrEn = 1'b0;
    // R3: first bit visible right after the write edge
    chk(sdo === tx[7], "R3", "sdo after write", int'(sdo), int'(tx[7]));
    while (h < 16 && n < 4000) begin
      bitIx = 7 - h / 2;
      hi = (h % 2) == 1;
      if (sck !== (pol ^ (early ? hi : !hi))) badSck++;
      if (sdo !== tx[bitIx]) badSdo++;
      if (sdoOe !== oe) badOe++;
      sdi = hi ? fin[bitIx] : mid[bitIx];
      tick = (rate == 3) && (n % 3 == 1);
      timerTick = tick;
      if (collide && n == 5) begin
        bufWrEn = 1'b1;
        bufWrData = ~tx;
      end
      @(posedge clk);
      n++;
      if (rate == 3) begin
        if (tick) h++;
      end else begin
        h = n / halfLen;
      end
      @(negedge clk);
      bufWrEn = 1'b0;
      timerTick = 1'b0;
    end
    chk(badSck == 0, "R5", "sck shape mismatches", badSck, 0);
    chk(badSdo == 0, "R1", "sdo bit mismatches", badSdo, 0);
    chk(badOe == 0, oe ? "R5" : "R7", "sdoOe mismatches", badOe, 0);
    chk(n == expN, "R2", "cycles to load", n, expN);
    chk(bufFull === 1'b1, "R8", "bufFull at load", int'(bufFull), 1);
    chk(bufRdData === expRx, late ? "R6" : "R1", "received byte",
        int'(bufRdData), int'(expRx));
    chk(xferIrq === 1'b0, "R8", "irq one cycle late", int'(xferIrq), 0);
    chk(sck === pol, "R4", "sck idle", int'(sck), int'(pol));
    chk(wrCollide === collide, "R10", "collision flag", int'(wrCollide), int'(collide));
    step();
    chk(xferIrq === 1'b1, oe ? "R8" : "R7", "irq raised", int'(xferIrq), 1);
    step(); step(); step();
    chk(xferIrq === 1'b1, "R11", "irq held", int'(xferIrq), 1);
    irqClr = 1'b1;
    step();
    irqClr = 1'b0;
    chk(xferIrq === 1'b0, "R11", "irq cleared", int'(xferIrq), 0);
    bufRdEn = 1'b1;
    step();
    bufRdEn = 1'b0;
    chk(bufFull === 1'b0, "R9", "bufFull cleared", int'(bufFull), 0);
    chk(bufRdData === expRx, "R9", "data kept after read", int'(bufRdData), int'(expRx));
    if (collide) begin
      wrCollideClr = 1'b1;
      step();
      wrCollideClr = 1'b0;
      chk(wrCollide === 1'b0, "R10", "collision cleared", int'(wrCollide), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int idx;
    logic [7:0] tx, mid;
    cpol = 1'b1;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(xferIrq === 1'b0, "R12", "irq in reset", int'(xferIrq), 0);
    chk(bufFull === 1'b0, "R12", "bufFull in reset", int'(bufFull), 0);
    chk(wrCollide === 1'b0, "R12", "collide in reset", int'(wrCollide), 0);
    chk(bufRdData === 8'h00, "R12", "buffer in reset", int'(bufRdData), 0);
    chk(sck === 1'b1, "R12", "sck in reset", int'(sck), 1);
    rstN = 1'b1;
    step();
    idx = 0;
    for (int r = 0; r < 4; r++)
      for (int p = 0; p < 2; p++)
        for (int e = 0; e < 2; e++)
          for (int s = 0; s < 2; s++) begin
            tx  = 8'hA5 ^ 8'(idx * 37);
            mid = 8'(idx * 29 + 3);
            runXfer(r, p[0], e[0], s[0], 1'b1, tx, mid, ~mid, 1'b0);
            idx++;
          end
    // R7: receive-only line monitoring
    runXfer(0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 8'hD2, 8'h2D, 1'b0);
    runXfer(1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h81, 8'h6E, 8'h91, 1'b0);
    // R10: writes during a transfer
    runXfer(0, 1'b0, 1'b0, 1'b0, 1'b1, 8'hC3, 8'h5A, 8'hA5, 1'b1);
    runXfer(3, 1'b1, 1'b1, 1'b1, 1'b1, 8'h0F, 8'h77, 8'h88, 1'b1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule